// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Deep-Sleep Sequencing

This block sits between a synchronous host and an asynchronous static RAM that has a low-power deep-sleep pin and an error flag output. The host issues single reads and writes through a valid/ready handshake. The controller turns each request into chip-select, output-enable and write-strobe sequences whose phase lengths are nanosecond limits rounded up to whole clock cycles. It controls the direction of the split data bus. On a read it returns the memory data together with the single-bit-corrected flag.

Two separate one-cycle command inputs put the memory to sleep and wake it. Entry holds the sleep pin low for a minimum pulse width, which also covers the settling time. The chip select is kept high for the whole wake-up window, so the deadline for raising it after wake is always met. Accesses are refused until the wake-up delay has passed. Host requests that arrive while the memory is unavailable are stalled with ready low and are served later, so none is lost.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: While and after reset, mem_ce_n, mem_oe_n, mem_we_n and mem_ds_n are high, mem_drv is low, req_ready is high, busy is low and rsp_valid is low.
- R2: An accepted read (req_we = 0) drives mem_ce_n and mem_oe_n low with the latched address for RD_CYC = ceil(T_ACC_NS / CLK_NS) cycles. rsp_valid then pulses for exactly one cycle, RD_CYC + 1 cycles after the accepting clock edge, carrying the data sampled at the end of the strobe.
- R3: An accepted write (req_we = 1) first spends TURN_CYC = ceil(T_HZ_NS / CLK_NS) cycles with mem_ce_n low, mem_we_n high and the bus released. It then holds mem_we_n low for WP_CYC = ceil(T_WP_NS / CLK_NS) cycles with the write data driven (mem_drv = 1). It produces no response.
- R4: mem_drv is never high while mem_oe_n is low. mem_we_n low always comes with mem_drv high and mem_ce_n low.
- R5: A sleep_req pulse taken while idle drives mem_ds_n low on the next cycle. During sleep all other strobes stay high, mem_drv is low, req_ready is low and busy is high.
- R6: mem_ds_n stays low for at least HOLD_CYC = max(ceil(T_PDS_NS / CLK_NS), ceil(T_SETTLE_NS / CLK_NS)) cycles. A wake_req received earlier is remembered, and the exit then happens after exactly HOLD_CYC low cycles. Without a wake_req the memory stays asleep.
- R7: After mem_ds_n rises, mem_ce_n stays high and req_ready low for WAKE_CYC = ceil(T_WAKE_NS / CLK_NS) cycles. req_ready is high in the cycle that follows.
- R8: A request held valid during sleep or wake is not accepted until the wake delay ends. It is then served with correct data.
- R9: A sleep_req that arrives during an access takes effect when that access ends, ahead of any request waiting at that point.
- R10: wake_req while awake has no effect, so a later sleep still needs its own wake_req. sleep_req while asleep has no effect, so the block stays awake after the next wake.
- R11: rsp_err returns the mem_err level sampled in the same edge as rsp_rdata.
- R12: busy is high whenever the block is not idle and awake. req_ready high implies busy low and mem_ds_n high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, period CLK_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Corrected-error flag of the read |
| sleep_req | input | 1 | One-cycle command to enter deep sleep |
| wake_req | input | 1 | One-cycle command to leave deep sleep |
| busy | output | 1 | Access, sleep or wake in progress |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_drv | output | 1 | Bus direction, 1 = controller drives |
| mem_din | input | DATA_W | Data returned by the memory |
| mem_err | input | 1 | Memory error flag |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ds_n | output | 1 | Deep-sleep control, low = sleep |

## Verification
The assertions assume that sleep_req and wake_req are single-cycle pulses. They also assume that the host keeps a request stable while valid is high and ready is low, and that the memory returns data and flag within the rounded access window. The bench obeys these assumptions. It drives every input at the falling edge, holds each request until it sees ready, and issues commands as one-cycle pulses. Its memory model answers combinationally and records data only while a write strobe overlaps chip select and bus drive. A small address space allows a full write and read sweep.

// File: rtl/ssc_pkg.sv
// Package: shared state type and ns-to-cycle helpers for the SRAM controller.
// Assumes all time parameters are non-negative integers in nanoseconds.
package ssc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WTURN,
        ST_WPULSE,
        ST_SLEEP,
        ST_WAKE
    } ssc_state_e;

    // Round a nanosecond limit up to whole cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ssc_timer.sv
// Phase timer: loads a count and decrements to zero; done while zero.
// Assumes the loader writes (phase length - 1) on entry to a phase.
module ssc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/ssc_fsm.sv
// Sequencer: access phases, sleep entry/hold, wake delay and registered
// memory strobes. Assumes sleep_req/wake_req are single-cycle pulses.
module ssc_fsm
    import ssc_pkg::*;
#(
    parameter int RD_CYC   = 1,
    parameter int TURN_CYC = 1,
    parameter int WP_CYC   = 1,
    parameter int HOLD_CYC = 1,
    parameter int WAKE_CYC = 1,
    parameter int TMR_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_we,
    input  logic sleep_req,
    input  logic wake_req,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic busy,
    output logic mem_ce_n,
    output logic mem_oe_n,
    output logic mem_we_n,
    output logic mem_ds_n,
    output logic mem_drv
);
    ssc_state_e        state_q, state_d;
    logic              sleep_pend_q, wake_pend_q;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;

    ssc_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign req_ready = (state_q == ST_IDLE) && !sleep_pend_q;
    assign accept    = req_ready && req_valid;
    assign busy      = (state_q != ST_IDLE);

    // Next-state and phase-timer loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (sleep_pend_q) begin
                    state_d  = ST_SLEEP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HOLD_CYC - 1);
                end else if (accept && req_we) begin
                    state_d  = ST_WTURN;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TURN_CYC - 1);
                end else if (accept) begin
                    state_d  = ST_READ;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RD_CYC - 1);
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WTURN: begin
                if (tmr_done) begin
                    state_d  = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(WP_CYC - 1);
                end
            end
            ST_WPULSE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_SLEEP: begin
                if (tmr_done && wake_pend_q) begin
                    state_d  = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remember a sleep command until the block is idle; ignored while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   sleep_pend_q <= 1'b0;
        else if (state_q == ST_IDLE && sleep_pend_q)  sleep_pend_q <= 1'b0;
        else if (sleep_req && state_q != ST_SLEEP)    sleep_pend_q <= 1'b1;
    end

    // Remember a wake command only while the sleep pin is held low.
    always_ff @(posedge clk) begin
        if (!rst_n)                   wake_pend_q <= 1'b0;
        else if (state_q != ST_SLEEP) wake_pend_q <= 1'b0;
        else if (state_d == ST_WAKE)  wake_pend_q <= 1'b0;
        else if (wake_req)            wake_pend_q <= 1'b1;
    end

    // Registered strobes decoded from the next state, aligned with state_q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_ds_n <= 1'b1;
            mem_drv  <= 1'b0;
        end else begin
            mem_ce_n <= !(state_d inside {ST_READ, ST_WTURN, ST_WPULSE});
            mem_oe_n <= !(state_d == ST_READ);
            mem_we_n <= !(state_d == ST_WPULSE);
            mem_ds_n <= !(state_d == ST_SLEEP);
            mem_drv  <= (state_d == ST_WPULSE);
        end
    end
endmodule

// File: rtl/ssc_datapath.sv
// Datapath: latches address/write data on accept, captures read data and
// error flag at the end of the read strobe, emits a one-cycle response.
module ssc_datapath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    // Hold request fields stable for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
        end
    end

    // Sample data and flag together; pulse the response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= mem_din;
                rsp_err   <= mem_err;
            end
        end
    end
endmodule

// File: rtl/sram_sleep_ctrl.sv
// Top: host-side controller for an asynchronous SRAM with deep sleep.
// Timing limits are given in ns and rounded up to cycles of CLK_NS.
// Assumes the host holds a request stable until it is accepted.
module sram_sleep_ctrl
    import ssc_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 10,
    parameter int T_ACC_NS    = 10,
    parameter int T_HZ_NS     = 5,
    parameter int T_WP_NS     = 7,
    parameter int T_PDS_NS    = 100,
    parameter int T_SETTLE_NS = 1000000,
    parameter int T_WAKE_NS   = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic              sleep_req,
    input  logic              wake_req,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_drv,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_err,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ds_n
);
    localparam int RD_CYC   = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int HOLD_CYC = imax(ns_to_cyc(T_PDS_NS, CLK_NS),
                                   ns_to_cyc(T_SETTLE_NS, CLK_NS));
    localparam int WAKE_CYC = ns_to_cyc(T_WAKE_NS, CLK_NS);
    localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC),
                                   imax(WP_CYC, imax(HOLD_CYC, WAKE_CYC)));
    localparam int TMR_W    = $clog2(MAX_CYC + 1);

    logic accept, capture;

    ssc_fsm #(
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .WAKE_CYC (WAKE_CYC),
        .TMR_W    (TMR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .busy      (busy),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_ds_n  (mem_ds_n),
        .mem_drv   (mem_drv)
    );

    ssc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_din   (mem_din),
        .mem_err   (mem_err),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );
endmodule

// File: rtl/ssc_checker.sv
// Checker bound to sram_sleep_ctrl: strobe exclusivity, minimum sleep
// pulse, wake-up gap and write pulse width, using run-length counters.
module ssc_checker #(
    parameter int WP_CYC   = 1,
    parameter int HOLD_CYC = 1,
    parameter int WAKE_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_ds_n,
    input logic mem_drv,
    input logic req_ready,
    input logic busy,
    input logic rsp_valid
);
    localparam int HW = $clog2(HOLD_CYC + 2);
    localparam int KW = $clog2(WAKE_CYC + 2);
    localparam int PW = $clog2(WP_CYC + 2);

    logic [HW-1:0] ds_low_cnt;
    logic [KW-1:0] wake_cnt;
    logic [PW-1:0] we_low_cnt;

    // Length of the current sleep-pin low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ds_low_cnt <= '0;
        else if (mem_ds_n)                      ds_low_cnt <= '0;
        else if (ds_low_cnt < HW'(HOLD_CYC))    ds_low_cnt <= ds_low_cnt + 1'b1;
    end

    // Cycles since the sleep pin went high, saturating; full after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             wake_cnt <= KW'(WAKE_CYC);
        else if (!mem_ds_n)                     wake_cnt <= '0;
        else if (wake_cnt < KW'(WAKE_CYC))      wake_cnt <= wake_cnt + 1'b1;
    end

    // Length of the current write-strobe low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                             we_low_cnt <= '0;
        else if (mem_we_n)                      we_low_cnt <= '0;
        else if (we_low_cnt < PW'(WP_CYC))      we_low_cnt <= we_low_cnt + 1'b1;
    end

    a_r5_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ds_n |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_drv && busy));

    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drv |-> mem_oe_n);

    a_r4_we_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_drv && !mem_ce_n));

    a_r6_min_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ds_n) |-> (ds_low_cnt >= HW'(HOLD_CYC)));

    a_r7_wake_gap_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (wake_cnt >= KW'(WAKE_CYC)));

    a_r7_wake_gap_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (wake_cnt >= KW'(WAKE_CYC)));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= PW'(WP_CYC)));

    a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!busy && mem_ds_n));
endmodule

bind sram_sleep_ctrl ssc_checker #(
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .WAKE_CYC (WAKE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ds_n  (mem_ds_n),
    .mem_drv   (mem_drv),
    .req_ready (req_ready),
    .busy      (busy),
    .rsp_valid (rsp_valid)
);

// File: tb/sram_sleep_ctrl_tb.sv
// Bench: full write/read sweep over a 16-word memory model, then sleep,
// wake, stall and ordering scenarios with cycle-exact expectations.
module sram_sleep_ctrl_tb;
    localparam int CLK_NS = 10;
    // Expected cycle counts, worked out by hand from the ns values below.
    localparam int E_RD   = 3;   // 25 ns
    localparam int E_WP   = 2;   // 12 ns
    localparam int E_HOLD = 15;  // max(100, 150) ns
    localparam int E_WAKE = 30;  // 300 ns

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_we = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       sleep_req = 1'b0, wake_req = 1'b0;
    logic       req_ready, rsp_valid, rsp_err, busy;
    logic [7:0] rsp_rdata, mem_dout, mem_din;
    logic [3:0] mem_addr;
    logic       mem_drv, mem_err, mem_ce_n, mem_oe_n, mem_we_n, mem_ds_n;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sram_sleep_ctrl #(
        .ADDR_W(4), .DATA_W(8), .CLK_NS(CLK_NS), .T_ACC_NS(25), .T_HZ_NS(8),
        .T_WP_NS(12), .T_PDS_NS(100), .T_SETTLE_NS(150), .T_WAKE_NS(300)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .sleep_req(sleep_req), .wake_req(wake_req), .busy(busy),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_drv(mem_drv),
        .mem_din(mem_din), .mem_err(mem_err), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ds_n(mem_ds_n)
    );

    // Memory model: stores on strobe overlap, answers combinationally.
    logic [7:0] marr [16];
    always @(posedge clk)
        if (!mem_ce_n && !mem_we_n && mem_drv) marr[mem_addr] <= mem_dout;
    assign mem_din = (!mem_ce_n && !mem_oe_n) ? marr[mem_addr] : 8'h00;
    assign mem_err = (!mem_ce_n && !mem_oe_n) ? (mem_addr[0] ^ mem_addr[3]) : 1'b0;

    // Monitors: write-strobe run length and bus contention.
    int we_run = 0, we_last = 0, contend = 0;
    always @(posedge clk) begin
        if (!mem_we_n) we_run <= we_run + 1;
        else begin
            if (we_run != 0) we_last <= we_run;
            we_run <= 0;
        end
        if (rst_n && mem_drv && !mem_oe_n) contend <= contend + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic send(input logic we, input logic [3:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        send(1'b1, a, d);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d,
                           output logic e, output int lat);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end while (!rsp_valid && lat < 100);
        d = rsp_rdata; e = rsp_err;
        @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       e;
        int         lat, cnt;

        repeat (3) @(negedge clk);
        chk("R1 ce_n in reset", mem_ce_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes high", {mem_ce_n, mem_oe_n, mem_we_n, mem_ds_n}, 4'hF);
        chk("R1 drv low", mem_drv, 0);
        chk("R1 ready/busy/rsp", {req_ready, busy, rsp_valid}, 3'b100);

        // R3: exhaustive write sweep with pulse width check.
        for (int a = 0; a < 16; a++) begin
            do_write(4'(a), pat(a));
            chk("R3 write pulse cycles", we_last, E_WP);
        end
        chk("R3 no response on write", rsp_valid, 0);

        // R2/R11: exhaustive read sweep: data, flag and latency.
        for (int a = 0; a < 16; a++) begin
            do_read(4'(a), d, e, lat);
            chk("R2 read data", d, pat(a));
            chk("R11 error flag", e, (a & 1) ^ ((a >> 3) & 1));
            chk("R2 latency", lat, E_RD + 1);
        end

        // R4: write directly after read at the same address.
        do_read(4'd9, d, e, lat);
        do_write(4'd9, 8'hA5);
        do_read(4'd9, d, e, lat);
        chk("R4 turnaround data", d, 8'hA5);
        chk("R4 no contention", contend, 0);

        // R5/R6/R7: sleep with an early wake.
        pulse_sleep();
        while (mem_ds_n) @(negedge clk);
        chk("R5 asleep strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_drv}, 4'b1110);
        chk("R5 ready low busy high", {req_ready, busy}, 2'b01);
        cnt = 0;
        while (!mem_ds_n && cnt < 1000) begin
            cnt++;
            if (cnt == 3) wake_req = 1'b1;
            @(negedge clk);
            wake_req = 1'b0;
        end
        chk("R6 early wake hold cycles", cnt, E_HOLD);
        cnt = 0; lat = 0;
        while (!req_ready && cnt < 1000) begin
            cnt++;
            if (!mem_ce_n) lat++;
            @(negedge clk);
        end
        chk("R7 wake delay cycles", cnt, E_WAKE);
        chk("R7 ce_n held high", lat, 0);

        // R10: wake while awake ignored; stays asleep without a new wake.
        pulse_wake();
        pulse_sleep();
        repeat (60) @(negedge clk);
        chk("R10 stays asleep", mem_ds_n, 0);
        pulse_sleep();  // ignored while asleep
        // R8: request held during sleep is stalled, then served.
        req_valid = 1'b1; req_we = 1'b0; req_addr = 4'd3;
        pulse_wake();
        cnt = 0;
        while (!req_ready && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R8 stalled until wake done", (cnt > E_WAKE) ? 1 : 0, 1);
        chk("R8 awake when accepted", mem_ds_n, 1);
        do_read(4'd3, d, e, lat);
        chk("R8 stalled read data", d, pat(3));
        repeat (20) @(negedge clk);
        chk("R10 sleep while asleep ignored", {mem_ds_n, busy}, 2'b10);

        // R9: sleep during a write beats a waiting read.
        req_valid = 1'b1; req_we = 1'b1; req_addr = 4'd6; req_wdata = 8'h3C;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_we = 1'b0;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        cnt = 0;
        while (mem_ds_n && !req_ready && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk("R9 sleep before waiting read", mem_ds_n, 0);
        chk("R12 busy while asleep", busy, 1);
        pulse_wake();
        cnt = 0;
        while (!rsp_valid && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            req_valid = req_valid && !(!busy && !req_ready) ? req_valid : 1'b0;
            if (busy && mem_ds_n && !mem_oe_n) req_valid = 1'b0;
        end
        chk("R9 waiting read served", rsp_rdata, 8'h3C);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 idle awake not busy", {busy, req_ready}, 2'b01);
        chk("R4 final no contention", contend, 0);

        summary();
        $finish;
    end
endmodule